// File: doc/BRIEF.md
# Serial Channel Control and Status Unit

This block is the register-side half of an asynchronous serial channel. It keeps the channel's control settings (per-direction enables, interrupt enables, an address-wake filter enable and the serial clock pin selection) and its status flags (transmit buffer empty, receive buffer full, overrun, framing error, parity error, transmit end and the received address bit). It sits between a simple register bus and a shift-register transmitter/receiver core. Software loads a byte into the transmit buffer, then hands it over by clearing the empty flag. The core reports each received frame as a one-cycle parallel strobe.

Status flags are cleared with a two-step handshake. Software must first read the flag as 1, and only then does a write of 0 take effect. When address-wake filtering is on, data frames are dropped without a trace. The first frame that carries the address bit is stored, and that frame also switches the filter off by itself. The block combines flags and enables into four interrupt requests. It also decides whether the serial clock pin is a plain port pin, a clock output, or a fixed level.

Register map (3-bit address): 0 control, 1 status, 2 transmit buffer (read/write), 3 receive data (read only), 4 mode (bit 0 = level mode). Control bits: 7 tx irq enable, 6 rx irq enable, 5 tx enable, 4 rx enable, 3 wake filter enable, 2 tx-end irq enable, 1 clock select high, 0 clock select low. Status bits: 7 tx empty, 6 rx full, 5 overrun, 4 framing error, 3 parity error, 2 tx end, 1 address bit, 0 reads 0.

Top module: `uart_ctl_core`

## Requirements
- R1: After reset the control and mode registers read 0x00, status reads 0x84 (tx empty and tx end set), all interrupt outputs are 0, the clock pin is not driven and the core enables are low.
- R2: While tx enable (control bit 5) is 0, tx empty (status bit 7) reads 1 and cannot be cleared; clearing tx enable returns tx empty to 1 on the next cycle.
- R3: A write of 0 to a clearable status bit (bits 7 to 3) clears it only if the status register was read with that bit at 1 since the bit last became set; a write of 1 changes nothing, and a write of 0 without such a read changes nothing.
- R4: With tx enable set, once tx empty is cleared, core_tx_start pulses for one cycle with the buffered byte as soon as core_tx_busy is low, and tx empty reads 1 again afterwards.
- R5: Tx end (status bit 2) is cleared together with a successful clear of tx empty and is set when core_tx_done arrives while tx empty is 1.
- R6: With rx enable set, an accepted frame is placed in receive data when rx full is 0, sets rx full, and ORs its framing and parity errors into status bits 4 and 3; status bit 1 takes the frame's address bit.
- R7: A frame accepted while rx full is 1 sets overrun (status bit 5) and leaves receive data and the error bits unchanged.
- R8: While rx enable is 0, frames are ignored and clearing rx enable leaves every status flag as it was.
- R9: While the wake filter (control bit 3) is 1, a frame with address bit 0 changes neither receive data nor any status flag.
- R10: A frame with address bit 1 received while the wake filter is on clears the wake filter bit and is stored as a normal frame.
- R11: irq_tx = tx irq enable and tx empty; irq_end = tx-end irq enable and tx end; irq_rx = rx irq enable and rx full and not wake filter; irq_err = rx irq enable and any of overrun/framing/parity and not wake filter.
- R12: Clock pin: in mode 0, select low 0 leaves the pin undriven and select low 1 drives baud_clk; in mode 1, selects 00 drive 0, 10 drive 1, and 01 or 11 drive baud_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms flag clearing) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| core_tx_busy | input | 1 | Transmitter shifting |
| core_tx_done | input | 1 | Transmitter finished a frame |
| core_tx_start | output | 1 | Load-and-start pulse to the transmitter |
| core_tx_byte | output | DATA_W | Byte handed to the transmitter |
| core_rx_en | output | 1 | Receiver start-bit hunt enable |
| core_rx_valid | input | 1 | Frame complete strobe |
| core_rx_byte | input | DATA_W | Received byte |
| core_rx_mpb | input | 1 | Received address bit |
| core_rx_ferr | input | 1 | Received frame had a framing error |
| core_rx_perr | input | 1 | Received frame had a parity error |
| baud_clk | input | 1 | Serial clock from the rate generator |
| sck_oe | output | 1 | Clock pin output enable |
| sck_o | output | 1 | Clock pin output value |
| irq_tx | output | 1 | Transmit buffer empty request |
| irq_rx | output | 1 | Receive data full request |
| irq_err | output | 1 | Receive error request |
| irq_end | output | 1 | Transmit end request |

## Verification
A stuck or wrongly armed flag shows up on the very next status read and on the interrupt outputs within one cycle, because every request is a direct combination of stored state. A wake filter that fails to drop data frames, or fails to switch itself off, shows up as changed receive data or a wrong control readback right after the frame strobe. A transmit buffer handover that is lost or repeated shows up on core_tx_start in the first cycle the transmitter reports idle, and on tx empty one cycle after that.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;
  localparam int NCLR   = 5;  // clearable flags occupy status bits 7..3

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_STAT = 3'd1,
    A_TXB  = 3'd2,
    A_RXB  = 3'd3,
    A_MODE = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic txie;
    logic rxie;
    logic txen;
    logic rxen;
    logic wake;
    logic endie;
    logic ck1;
    logic ck0;
  } ctrl_t;

  typedef struct packed {
    logic tx_empty;
    logic rx_full;
    logic overrun;
    logic frame_err;
    logic parity_err;
    logic tx_end;
    logic mpb;
    logic rsvd;
  } stat_t;

  // Returns {output enable, output value} for the serial clock pin.
  function automatic logic [1:0] sck_drive(input logic lvl, input logic ck1,
                                           input logic ck0, input logic baud);
    if (!lvl) return ck0 ? {1'b1, baud} : 2'b00;
    if (ck0)  return {1'b1, baud};
    return {1'b1, ck1};
  endfunction

  // A frame passes the wake filter when the filter is off or it is an address frame.
  function automatic logic frame_passes(input logic wake, input logic mpb);
    return !wake || mpb;
  endfunction

  function automatic logic any_err(input stat_t s);
    return s.overrun | s.frame_err | s.parity_err;
  endfunction
endpackage

// File: rtl/uart_ctl_regs.sv
module uart_ctl_regs
  import uart_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_mode,
  input  logic [REG_W-1:0] wdata,
  input  logic             wake_clr,
  output ctrl_t            ctrl,
  output logic             lvl_mode
);
  ctrl_t ctrl_q;
  logic  lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata);
      if (wake_clr) ctrl_q.wake <= 1'b0;
      if (wr_mode) lvl_q <= wdata[0];
    end
  end

  assign ctrl     = ctrl_q;
  assign lvl_mode = lvl_q;
endmodule

// File: rtl/uart_rx_filter.sv
module uart_rx_filter
  import uart_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_en,
  input  logic              wake,
  input  logic              mpb,
  input  logic              rx_full,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              acc,
  output logic              addr_hit,
  output logic              store,
  output logic              ovr_set,
  output logic [DATA_W-1:0] rx_data
);
  logic              seen;
  logic [DATA_W-1:0] data_q;

  assign seen     = rx_valid && rx_en;
  assign acc      = seen && frame_passes(wake, mpb);
  assign addr_hit = seen && wake && mpb;
  assign store    = acc && !rx_full;
  assign ovr_set  = acc && rx_full;

  always_ff @(posedge clk) begin
    if (!rst_n)     data_q <= '0;
    else if (store) data_q <= rx_byte;
  end

  assign rx_data = data_q;
endmodule

// File: rtl/uart_flag_unit.sv
module uart_flag_unit
  import uart_ctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_rd,
  input  logic            stat_wr,
  input  logic [NCLR-1:0] wr_bits,
  input  logic            tx_en,
  input  logic            tx_start,
  input  logic            tx_done,
  input  logic            frame_acc,
  input  logic            store,
  input  logic            ovr_set,
  input  logic            ferr_in,
  input  logic            perr_in,
  input  logic            mpb_in,
  output stat_t           stat,
  output logic [NCLR-1:0] clr_fire
);
  localparam logic [NCLR-1:0] RST_V = {1'b1, {(NCLR-1){1'b0}}};
  localparam int TXE = NCLR - 1;

  logic [NCLR-1:0] flag_v, set_v, clr_req;
  logic            tend_q, mpb_q;

  assign set_v = {!tx_en || tx_start, store, ovr_set, store && ferr_in, store && perr_in};

  for (genvar i = 0; i < NCLR; i++) begin : g_flag
    logic f_q, a_q;
    assign clr_req[i] = stat_wr && !wr_bits[i] && a_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        f_q <= RST_V[i];
        a_q <= 1'b0;
      end else if (set_v[i]) begin
        f_q <= 1'b1;
        if (!f_q) a_q <= 1'b0;
        else if (stat_rd) a_q <= 1'b1;
      end else if (clr_req[i]) begin
        f_q <= 1'b0;
        a_q <= 1'b0;
      end else if (stat_rd && f_q) begin
        a_q <= 1'b1;
      end
    end
    assign flag_v[i] = f_q;
  end

  assign clr_fire = clr_req & ~set_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
      mpb_q  <= 1'b0;
    end else begin
      if (tx_done && flag_v[TXE]) tend_q <= 1'b1;
      else if (clr_fire[TXE])     tend_q <= 1'b0;
      if (frame_acc) mpb_q <= mpb_in;
    end
  end

  assign stat = stat_t'({flag_v, tend_q, mpb_q, 1'b0});
endmodule

// File: rtl/uart_sck_sel.sv
module uart_sck_sel
  import uart_ctl_pkg::*;
(
  input  logic lvl_mode,
  input  logic ck1,
  input  logic ck0,
  input  logic baud_clk,
  output logic sck_oe,
  output logic sck_o
);
  logic [1:0] drv;
  assign drv    = sck_drive(lvl_mode, ck1, ck0, baud_clk);
  assign sck_oe = drv[1];
  assign sck_o  = drv[0];
endmodule

// File: rtl/uart_ctl_core.sv
module uart_ctl_core
  import uart_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              core_tx_busy,
  input  logic              core_tx_done,
  output logic              core_tx_start,
  output logic [DATA_W-1:0] core_tx_byte,
  output logic              core_rx_en,
  input  logic              core_rx_valid,
  input  logic [DATA_W-1:0] core_rx_byte,
  input  logic              core_rx_mpb,
  input  logic              core_rx_ferr,
  input  logic              core_rx_perr,
  input  logic              baud_clk,
  output logic              sck_oe,
  output logic              sck_o,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_err,
  output logic              irq_end
);
  localparam int PAD = DATA_W - REG_W;

  ctrl_t             ctrl_q;
  stat_t             stat_w;
  logic              lvl_w;
  logic [DATA_W-1:0] txb_q, rx_data_w;
  logic              sel_ctrl, sel_stat, sel_txb, sel_mode;
  logic              acc_w, addr_hit_w, store_w, ovr_set_w;
  logic [NCLR-1:0]   clr_fire_w;

  // Named internal events for the checker.
  logic te_w, rx_en_w, wake_w, tx_empty_w, rx_full_w;

  assign sel_ctrl = bus_addr == A_CTRL;
  assign sel_stat = bus_addr == A_STAT;
  assign sel_txb  = bus_addr == A_TXB;
  assign sel_mode = bus_addr == A_MODE;

  uart_ctl_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_ctrl  (bus_wr && sel_ctrl),
    .wr_mode  (bus_wr && sel_mode),
    .wdata    (bus_wdata[REG_W-1:0]),
    .wake_clr (addr_hit_w),
    .ctrl     (ctrl_q),
    .lvl_mode (lvl_w)
  );

  uart_rx_filter #(.DATA_W(DATA_W)) u_rxf (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (core_rx_valid),
    .rx_en    (ctrl_q.rxen),
    .wake     (ctrl_q.wake),
    .mpb      (core_rx_mpb),
    .rx_full  (stat_w.rx_full),
    .rx_byte  (core_rx_byte),
    .acc      (acc_w),
    .addr_hit (addr_hit_w),
    .store    (store_w),
    .ovr_set  (ovr_set_w),
    .rx_data  (rx_data_w)
  );

  uart_flag_unit u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_rd   (bus_rd && sel_stat),
    .stat_wr   (bus_wr && sel_stat),
    .wr_bits   (bus_wdata[REG_W-1:REG_W-NCLR]),
    .tx_en     (ctrl_q.txen),
    .tx_start  (core_tx_start),
    .tx_done   (core_tx_done),
    .frame_acc (acc_w),
    .store     (store_w),
    .ovr_set   (ovr_set_w),
    .ferr_in   (core_rx_ferr),
    .perr_in   (core_rx_perr),
    .mpb_in    (core_rx_mpb),
    .stat      (stat_w),
    .clr_fire  (clr_fire_w)
  );

  uart_sck_sel u_sck (
    .lvl_mode (lvl_w),
    .ck1      (ctrl_q.ck1),
    .ck0      (ctrl_q.ck0),
    .baud_clk (baud_clk),
    .sck_oe   (sck_oe),
    .sck_o    (sck_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                txb_q <= '0;
    else if (bus_wr && sel_txb) txb_q <= bus_wdata;
  end

  assign core_tx_start = ctrl_q.txen && !stat_w.tx_empty && !core_tx_busy;
  assign core_tx_byte  = txb_q;
  assign core_rx_en    = ctrl_q.rxen;

  assign irq_tx  = ctrl_q.txie && stat_w.tx_empty;
  assign irq_end = ctrl_q.endie && stat_w.tx_end;
  assign irq_rx  = ctrl_q.rxie && !ctrl_q.wake && stat_w.rx_full;
  assign irq_err = ctrl_q.rxie && !ctrl_q.wake && any_err(stat_w);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata = {{PAD{1'b0}}, ctrl_q};
      A_STAT:  bus_rdata = {{PAD{1'b0}}, stat_w};
      A_TXB:   bus_rdata = txb_q;
      A_RXB:   bus_rdata = rx_data_w;
      A_MODE:  bus_rdata = {{(DATA_W-1){1'b0}}, lvl_w};
      default: bus_rdata = '0;
    endcase
  end

  assign te_w       = ctrl_q.txen;
  assign rx_en_w    = ctrl_q.rxen;
  assign wake_w     = ctrl_q.wake;
  assign tx_empty_w = stat_w.tx_empty;
  assign rx_full_w  = stat_w.rx_full;
endmodule

// File: rtl/uart_ctl_core_chk.sv
module uart_ctl_core_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              te,
  input logic              rx_en,
  input logic              wake,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              tx_start,
  input logic              addr_hit,
  input logic              store,
  input logic              ovr_set,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              rx_mpb,
  input logic              lvl,
  input logic              ck0,
  input logic              sck_oe,
  input logic              irq_tx,
  input logic              irq_rx
);
  a_r2_empty_forced: assert property (@(posedge clk) disable iff (!rst_n)
    !te |=> tx_empty);

  a_r4_start_refills: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> tx_empty);

  a_r7_overrun_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> $stable(rx_data));

  a_r8_rx_off_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |-> !store && !ovr_set);

  a_r9_data_frame_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_en && wake && !rx_mpb) |-> !store && !ovr_set);

  a_r10_wake_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |=> !wake);

  a_r11_irq_tx_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> tx_empty);

  a_r11_irq_rx_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> rx_full && !wake);

  a_r12_port_pin: assert property (@(posedge clk) disable iff (!rst_n)
    (!lvl && !ck0) |-> !sck_oe);
endmodule

bind uart_ctl_core uart_ctl_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .te       (te_w),
  .rx_en    (rx_en_w),
  .wake     (wake_w),
  .tx_empty (tx_empty_w),
  .rx_full  (rx_full_w),
  .tx_start (core_tx_start),
  .addr_hit (addr_hit_w),
  .store    (store_w),
  .ovr_set  (ovr_set_w),
  .rx_data  (rx_data_w),
  .rx_valid (core_rx_valid),
  .rx_mpb   (core_rx_mpb),
  .lvl      (lvl_w),
  .ck0      (ctrl_q.ck0),
  .sck_oe   (sck_oe),
  .irq_tx   (irq_tx),
  .irq_rx   (irq_rx)
);

// File: tb/uart_ctl_core_tb.sv
`timescale 1ns/1ps
module uart_ctl_core_tb;
  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, TXB = 3'd2, RXB = 3'd3, MODE = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       core_tx_busy = 1'b0, core_tx_done = 1'b0, core_tx_start;
  logic [7:0] core_tx_byte;
  logic       core_rx_en;
  logic       core_rx_valid = 1'b0, core_rx_mpb = 1'b0, core_rx_ferr = 1'b0, core_rx_perr = 1'b0;
  logic [7:0] core_rx_byte = '0;
  logic       baud_clk = 1'b0, sck_oe, sck_o;
  logic       irq_tx, irq_rx, irq_err, irq_end;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_ctl_core u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_tx_busy(core_tx_busy),
    .core_tx_done(core_tx_done), .core_tx_start(core_tx_start), .core_tx_byte(core_tx_byte),
    .core_rx_en(core_rx_en), .core_rx_valid(core_rx_valid), .core_rx_byte(core_rx_byte),
    .core_rx_mpb(core_rx_mpb), .core_rx_ferr(core_rx_ferr), .core_rx_perr(core_rx_perr),
    .baud_clk(baud_clk), .sck_oe(sck_oe), .sck_o(sck_o), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_err(irq_err), .irq_end(irq_end)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic frame(input logic [7:0] b, input logic m, input logic fe, input logic pe);
    @(negedge clk);
    core_rx_byte = b; core_rx_mpb = m; core_rx_ferr = fe; core_rx_perr = pe; core_rx_valid = 1'b1;
    @(negedge clk);
    core_rx_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; core_tx_busy = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    #1;
    check("R1 irqs", {irq_tx, irq_rx, irq_err, irq_end}, 4'b0000);
    check("R1 pins", {sck_oe, core_rx_en, core_tx_start}, 3'b000);
    rd(CTRL, d); check("R1 ctrl", d, 8'h00);
    rd(MODE, d); check("R1 mode", d, 8'h00);
    rd(STAT, d); check("R1 status", d, 8'h84);
  endtask

  task automatic t_tx();
    logic [7:0] d;
    do_reset();
    wr(CTRL, 8'h20);
    wr(STAT, 8'h00);                        // no prior read: ignored
    rd(STAT, d); check("R3 clear without read", d, 8'h84);
    wr(TXB, 8'h5A);
    core_tx_busy = 1'b1;
    wr(STAT, 8'h7F);                        // armed by the read above
    rd(STAT, d); check("R4 handover clears empty and end", d, 8'h00);
    check("R4 no start while busy", core_tx_start, 1'b0);
    @(negedge clk); core_tx_busy = 1'b0;
    #1 check("R4 start pulse", {core_tx_start, core_tx_byte}, {1'b1, 8'h5A});
    @(negedge clk);
    #1 check("R4 start one cycle", core_tx_start, 1'b0);
    rd(STAT, d); check("R4 empty refilled, R5 end still 0", d, 8'h80);
    @(negedge clk); core_tx_done = 1'b1;
    @(negedge clk); core_tx_done = 1'b0;
    rd(STAT, d); check("R5 tx end set", d, 8'h84);
    wr(CTRL, 8'hA4);
    #1 check("R11 tx and end irqs", {irq_tx, irq_end}, 2'b11);
    core_tx_busy = 1'b1;
    rd(STAT, d);
    wr(STAT, 8'h7F);
    #1 check("R11 tx irq drops", {irq_tx, irq_end}, 2'b00);
    wr(CTRL, 8'h00);
    rd(STAT, d); check("R2 empty forced by tx disable", d, 8'h80);
    wr(STAT, 8'h00);
    rd(STAT, d); check("R2 empty not clearable", d, 8'h80);
    core_tx_busy = 1'b0;
  endtask

  task automatic t_rx();
    logic [7:0] d;
    do_reset();
    wr(CTRL, 8'h50);
    check("R6 core rx enable", core_rx_en, 1'b1);
    frame(8'h3C, 1'b0, 1'b0, 1'b0);
    rd(STAT, d); check("R6 full set", d, 8'hC4);
    rd(RXB, d);  check("R6 data stored", d, 8'h3C);
    check("R11 rx irq", {irq_rx, irq_err}, 2'b10);
    frame(8'h11, 1'b0, 1'b1, 1'b0);
    rd(STAT, d); check("R7 overrun only", d, 8'hE4);
    rd(RXB, d);  check("R7 data kept", d, 8'h3C);
    check("R11 err irq", irq_err, 1'b1);
    wr(STAT, 8'h9F);
    rd(STAT, d); check("R3 armed clear", d, 8'h84);
    frame(8'h77, 1'b1, 1'b1, 1'b1);
    wr(STAT, 8'h00);                        // set after last read: not armed
    rd(STAT, d); check("R3 new set needs read, R6 errors and address bit", d, 8'hDE);
    rd(RXB, d);  check("R6 second data", d, 8'h77);
    wr(CTRL, 8'h40);
    check("R8 core rx disabled", core_rx_en, 1'b0);
    rd(STAT, d); check("R8 flags kept", d, 8'hDE);
    frame(8'h55, 1'b0, 1'b0, 1'b0);
    rd(RXB, d);  check("R8 frame ignored data", d, 8'h77);
    rd(STAT, d); check("R8 frame ignored flags", d, 8'hDE);
  endtask

  task automatic t_wake();
    logic [7:0] d;
    do_reset();
    wr(CTRL, 8'h58);
    frame(8'h22, 1'b0, 1'b1, 1'b1);
    rd(STAT, d); check("R9 flags untouched", d, 8'h84);
    rd(RXB, d);  check("R9 data untouched", d, 8'h00);
    rd(CTRL, d); check("R9 filter stays on", d, 8'h58);
    frame(8'h09, 1'b1, 1'b0, 1'b0);
    rd(CTRL, d); check("R10 filter self-clears", d, 8'h50);
    rd(STAT, d); check("R10 stored with address bit", d, 8'hC6);
    rd(RXB, d);  check("R10 data", d, 8'h09);
    check("R11 rx irq after wake", irq_rx, 1'b1);
    wr(CTRL, 8'h58);
    #1 check("R11 rx irq masked by filter", irq_rx, 1'b0);
  endtask

  task automatic t_sck();
    logic [1:0] exp;
    do_reset();
    for (int lvl = 0; lvl < 2; lvl++) begin
      wr(MODE, 8'(lvl));
      for (int ck = 0; ck < 4; ck++) begin
        wr(CTRL, 8'(ck));
        for (int b = 0; b < 2; b++) begin
          baud_clk = b[0];
          if (lvl == 0) exp = (ck % 2 == 1) ? {1'b1, b[0]} : 2'b00;
          else if (ck == 0) exp = 2'b10;
          else if (ck == 2) exp = 2'b11;
          else exp = {1'b1, b[0]};
          #1 check($sformatf("R12 mode %0d sel %0d clk %0d", lvl, ck, b), {sck_oe, sck_o}, exp);
        end
      end
    end
    baud_clk = 1'b0;
  endtask

  initial begin
    t_reset();
    t_tx();
    t_rx();
    t_wake();
    t_sck();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule